// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 8 bits. The host presents one single-word read or write at a time through a valid/ready handshake. The controller turns each request into timed pin activity: a 17-bit address, an active-low and an active-high chip enable, write enable, output enable, and a split data bus made of an output value, a drive enable and an input value. When a transfer finishes, the controller raises a one-clock done pulse. A completed read also returns the captured byte.

The length of each phase is a parameter in clock cycles. The block derives these counts at elaboration by rounding the 12 ns access and cycle times and the 6 ns output-enable access time up to whole clock periods. When idle, the RAM is held in standby. Around the data bus, the controller never drives the pins while the RAM could be driving them.

Top module: `sram_ctrl`

## Requirements
- R1: In reset and whenever idle, the controller holds standby: the active-low enable is 1, the active-high enable is 0, write enable and output enable are 1, the data drive enable is 0, and ready is 1.
- R2: An accepted read drives the request address, the active-low enable at 0, the active-high enable at 1, write enable at 1 and output enable at 0 from the clock after acceptance.
- R3: A read samples the data bus after RD_CYC = max(ceil(12 ns/Tclk), ceil(6 ns/Tclk)) cycles with address and output enable asserted. Done and the byte appear RD_CYC clocks after the accepting edge (2 at 100 MHz).
- R4: The data drive enable is 1 only while output enable is 1. Write enable and output enable are never 0 together.
- R5: A write first spends one setup clock with address and data driven and write enable at 1. It then holds write enable at 0 for WP_CYC = ceil(12 ns/Tclk) clocks (2 at 100 MHz). Address and data stay unchanged through that pulse and for one clock after write enable rises, with both enables still active.
- R6: Done is a single-clock pulse. For a write it appears WP_CYC+2 clocks after the accepting edge.
- R7: Ready is 0 from the accepting edge until one clock after done. A request presented while ready is 0 has no effect.
- R8: Reset during a transfer returns every pin to standby at once and produces no done pulse.
- R9: In the clock that carries done, both enables are already deasserted. Consecutive transfers are therefore separated by at least one deselected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| sram_addr | output | 17 | RAM address pins |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Value for the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 8 | Value read from the data pins |

## Verification
A phase counter that is wrong, or a state that is skipped, shows up in one of two ways. Either done arrives a clock early or late, or the captured byte is the stale filler that the bench's time-aware RAM model returns before 12 ns have passed. Both are visible in the cycle where done is expected. A wrong pin decode shows up sooner, in the first clock after acceptance. It appears as a driven bus while output enable is low, as an address or data change under a low write enable, or as enables that are still active when done appears. The bench model counts these as violations as they happen.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_RECOV  = 3'd5
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_STANDBY = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rdata_out = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int CLK_PS      = 10000,
  parameter int T_ACCESS_PS = 12000,
  parameter int T_OE_PS     = 6000,
  parameter int T_CYCLE_PS  = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int AA_CYC  = ceil_div(T_ACCESS_PS, CLK_PS);
  localparam int OE_CYC  = ceil_div(T_OE_PS, CLK_PS);
  localparam int RD_RAW  = (AA_CYC > OE_CYC) ? AA_CYC : OE_CYC;
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_RAW  = ceil_div(T_CYCLE_PS, CLK_PS);
  localparam int WP_CYC  = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  ctrl_state_e      state_q, state_d;
  pin_ctl_t         pins_q, pins_d;
  logic             done_q, done_d;
  logic             accept, capture, tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  assign accept = (state_q == ST_IDLE) && req_valid;

  // Next-state and timer control
  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = RD_LOAD;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_write) state_d = ST_WSETUP;
        else begin
          state_d  = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = RD_LOAD;
        end
      end
      ST_READ: if (tmr_expired) begin
        state_d = ST_RECOV;
        capture = 1'b1;
        done_d  = 1'b1;
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WPULSE: if (tmr_expired) state_d = ST_WHOLD;
      ST_WHOLD: begin
        state_d = ST_RECOV;
        done_d  = 1'b1;
      end
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Pin decode of the next state, registered so the pins come from flops
  always_comb begin
    pins_d = PINS_STANDBY;
    unique case (state_d)
      ST_READ:   begin pins_d.ce_n = 1'b0; pins_d.ce = 1'b1; pins_d.oe_n = 1'b0; end
      ST_WSETUP,
      ST_WHOLD:  begin pins_d.ce_n = 1'b0; pins_d.ce = 1'b1; pins_d.dq_oe = 1'b1; end
      ST_WPULSE: begin pins_d.ce_n = 1'b0; pins_d.ce = 1'b1; pins_d.we_n = 1'b0;
                       pins_d.dq_oe = 1'b1; end
      default:   pins_d = PINS_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= PINS_STANDBY;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_d;
      done_q  <= done_d;
    end
  end

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .addr_in   (req_addr),
    .wdata_in  (req_wdata),
    .capture   (capture),
    .dq_in     (sram_dq_in),
    .addr_out  (sram_addr),
    .wdata_out (sram_dq_out),
    .rdata_out (rsp_rdata)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_done   = done_q;
  assign sram_ce_n  = pins_q.ce_n;
  assign sram_ce    = pins_q.ce;
  assign sram_we_n  = pins_q.we_n;
  assign sram_oe_n  = pins_q.oe_n;
  assign sram_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_ce,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R4

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n)); // R4

  AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R5

  AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_ce && sram_dq_oe && $stable(sram_addr))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R6

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready); // R7

  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (sram_ce_n && !sram_ce)); // R9
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_ce     (sram_ce),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int RD_N = 2;   // ceil(12/10)
  localparam int WP_N = 2;   // ceil(12/10)
  localparam int NVEC = 8;
  // {write, addr[16:0], wdata[7:0], expected read[7:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
    {1'b1, 17'h00123, 8'hFF, 8'h00},
    {1'b1, 17'h10000, 8'h00, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h00123, 8'h00, 8'hFF},
    {1'b0, 17'h10000, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rsp_rdata, sram_dq_out;
  logic [16:0] sram_addr;
  logic [7:0]  dq_in = 8'hEE;

  int checks = 0, failures = 0, viol = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_ce(sram_ce), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(dq_in)
  );

  // Behavioral RAM: valid data only 12 ns after address/select/output-enable settle
  logic [7:0] mem [logic [16:0]];
  realtime t_chg = 0;
  always @(sram_addr or sram_oe_n or sram_ce_n or sram_ce) t_chg = $realtime;
  always @(sram_addr or sram_dq_out)
    if (rst_n && !sram_we_n && !sram_ce_n && sram_ce) viol++;
  always @(posedge sram_we_n)
    if (rst_n && !sram_ce_n && sram_ce) begin
      if (!sram_dq_oe) viol++;
      mem[sram_addr] = sram_dq_out;
    end
  always @(negedge clk) begin
    if (!sram_ce_n && sram_ce && sram_we_n && !sram_oe_n) begin
      if (sram_dq_oe) viol++;
      if ($realtime - t_chg >= 12.0) dq_in = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
      else dq_in = 8'hEE;
    end else dq_in = 8'hEE;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_standby(input string tag);
    chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, tag,
        {sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 6'b101101);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n, we_cnt;
    @(negedge clk);
    chk(req_ready, "R7 ready before write", req_ready, 1);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    chk(!sram_ce_n && sram_ce && sram_we_n && sram_oe_n && sram_dq_oe && sram_addr == a
        && sram_dq_out == d, "R5 write setup", {sram_we_n, sram_dq_oe}, 2'b11);
    n = 1; we_cnt = 0;
    while (!rsp_done && n < 40) begin
      if (!sram_we_n) begin
        we_cnt++;
        chk(sram_addr == a && sram_dq_out == d && sram_oe_n, "R5 write pulse hold",
            sram_addr, a);
      end
      @(negedge clk); n++;
    end
    chk(n == WP_N + 3, "R6 write done timing", n - 1, WP_N + 2);
    chk(we_cnt == WP_N, "R5 we pulse width", we_cnt, WP_N);
    chk(!req_ready, "R7 ready low at done", req_ready, 0);
    chk(sram_ce_n && !sram_ce, "R9 deselected at done", {sram_ce_n, sram_ce}, 2'b10);
    @(negedge clk);
    chk(!rsp_done, "R6 done single pulse", rsp_done, 0);
    chk_standby("R1 standby after write");
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] e, input bit poke);
    int n;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(!sram_ce_n && sram_ce && sram_we_n && !sram_oe_n && !sram_dq_oe && sram_addr == a,
        "R2 read pins", sram_addr, a);
    if (poke) begin   // R7: request while busy must be ignored
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = 8'h77;
    end
    n = 1;
    while (!rsp_done && n < 40) begin @(negedge clk); n++; end
    req_valid = 0;
    chk(n == RD_N + 1, "R3 read done timing", n - 1, RD_N);
    chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
    chk(sram_ce_n && !sram_ce, "R9 deselected at done", {sram_ce_n, sram_ce}, 2'b10);
    chk(!req_ready, "R7 ready low at done", req_ready, 0);
    @(negedge clk);
    chk(!rsp_done, "R6 done single pulse", rsp_done, 0);
    chk(req_ready, "R7 ready after recovery", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_standby("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    chk_standby("R1 idle after reset");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][33]) do_write(VEC[i][32:16], VEC[i][15:8]);
      else            do_read(VEC[i][32:16], VEC[i][7:0], 1'b0);
    end

    // R7: write attempt while busy has no effect on memory contents
    do_read(17'h00000, 8'hA5, 1'b1);
    do_read(17'h00000, 8'hA5, 1'b0);

    // R8: reset during a read
    begin
      int seen = 0;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 17'h1FFFF;
      @(negedge clk);
      req_valid = 0;
      rst_n = 0;
      #1;
      chk_standby("R8 standby on mid-cycle reset");
      repeat (4) begin @(negedge clk); if (rsp_done) seen++; end
      rst_n = 1;
      repeat (4) begin @(negedge clk); if (rsp_done) seen++; end
      chk(seen == 0, "R8 no done after abort", seen, 0);
      chk_standby("R8 idle after abort");
    end

    do_read(17'h1FFFF, 8'h3C, 1'b0);
    chk(viol == 0, "R4 R5 bus model violations", viol, 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule